// File: doc/BRIEF.md
# Extended Feature Enable Register Access Unit

This unit owns the processor's extended-feature enable register, the register that tells the save/restore machinery which groups of architectural state are switched on. Software reaches it through one read operation and one write operation. A request names a register index and, for writes, carries a 64-bit value split into a high and a low 32-bit half. The unit checks legality against the current privilege level, the operating-system enable control bit, the set of features the core supports and a strap that says whether compacted save formats exist. It then returns read data, updates the register, raises a fault with a code, or asks the virtualization layer to take over.

Reads of index 0 return the register itself. Reads of index 1 return the per-feature in-use vector filtered by the register, when compaction is supported. Writes enforce the dependency rules between feature groups: the base floating-point bit can never be cleared, the upper-vector bit needs the vector bit, and the three wide-vector bits come as a set together with the lower groups. A request is taken in one cycle; the response and any register change are visible one cycle later, with a single-cycle strobe when the enabled feature set was rewritten.

Top module: `xcr_access_unit`

## Requirements
- R1: After reset the register reads as 0x1, no response is pending, and fault, exit request and mode-change strobe are low.
- R2: With the operating-system enable input low, both reads and writes fault with code 1 (undefined opcode); fault code 0 means no fault and code 2 means general protection.
- R3: A read of index 0 returns the register in bits 31:0 of the read data and zero in bits 63:32.
- R4: A read of index 1 returns the in-use vector ANDed with the register (upper half zero) when the compaction strap is high, and faults with code 2 when it is low.
- R5: A read of any index other than 0 or 1 faults with code 2.
- R6: A write in guest mode, once the enable check has passed, raises the exit request instead of any privilege or value fault and leaves the register unchanged; with the enable input low the undefined-opcode fault wins over the exit.
- R7: A write at a privilege level other than 0, or to an index other than 0, faults with code 2.
- R8: A write faults with code 2 if its high half is nonzero, if any low-half bit is outside the supported mask, or if bit 0 is clear.
- R9: A write faults with code 2 if bit 2 is set while bit 1 is clear.
- R10: If any of bits 5, 6 or 7 is written as 1, then bits 0, 1, 2, 5, 6 and 7 must all be 1, otherwise the write faults with code 2.
- R11: A faulting or exiting request leaves the register unchanged; a legal write loads the low half and pulses the mode-change strobe for one cycle, the new value appearing on the register output together with the response.
- R12: Every request produces exactly one single-cycle response valid pulse in the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| wr_hi | input | 32 | High half of the write value |
| wr_lo | input | 32 | Low half of the write value |
| cur_priv | input | 2 | Current privilege level |
| os_enable | input | 1 | Operating-system enable control bit |
| guest_mode | input | 1 | Core runs as a virtualized guest |
| supp_mask | input | 32 | Features the core can enable |
| inuse_vec | input | 32 | Per-feature non-initial state vector |
| compact_ok | input | 1 | Compacted save format supported |
| resp_valid | output | 1 | Response valid |
| rd_data | output | 64 | Read data |
| fault | output | 1 | Request faulted |
| fault_code | output | 2 | 0 none, 1 undefined opcode, 2 general protection |
| exit_req | output | 1 | Virtualization exit requested |
| mode_chg | output | 1 | Enabled feature set rewritten |
| xcr_value | output | 32 | Current register value |

## Verification
Reads are tried at index 0, at index 1 with the strap both high and low, and at a small and a large out-of-range index, which separates the three index decodes and the strap gating. Writes walk through each rejection rule alone with every other rule satisfied, so a fault can only come from the rule under test, and then through near-miss values such as a wide group missing one member, which tell a full-set check apart from an any-bit check. The priority of the enable check over the guest exit and of the exit over the privilege check is tried by combining those inputs, and read-backs after every rejected write show the register kept its value.

// File: rtl/xcr_pkg.sv
package xcr_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } flt_e;

  // Feature bit positions; the dependency rules are defined on them.
  localparam int BIT_X87   = 0;
  localparam int BIT_VEC   = 1;
  localparam int BIT_UPVEC = 2;
  localparam int WIDE_LO   = 5;
  localparam int WIDE_HI   = 7;

  typedef struct packed {
    logic fault;
    flt_e code;
    logic exit_req;
  } verdict_t;

endpackage

// File: rtl/xcr_rd_path.sv
module xcr_rd_path
  import xcr_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int INDEX_W = 32
) (
  input  logic               os_enable,
  input  logic [INDEX_W-1:0] index,
  input  logic               compact_ok,
  input  logic [REG_W-1:0]   xcr,
  input  logic [REG_W-1:0]   inuse_vec,
  output logic [2*REG_W-1:0] data,
  output verdict_t           verdict
);

  localparam logic [INDEX_W-1:0] IDX_REG   = '0;
  localparam logic [INDEX_W-1:0] IDX_INUSE = INDEX_W'(1);

  always_comb begin
    data    = '0;
    verdict = '{fault: 1'b0, code: FLT_NONE, exit_req: 1'b0};
    if (!os_enable) begin
      verdict.fault = 1'b1;
      verdict.code  = FLT_UD;
    end else if (index == IDX_REG) begin
      data = {{REG_W{1'b0}}, xcr};
    end else if (index == IDX_INUSE && compact_ok) begin
      data = {{REG_W{1'b0}}, xcr & inuse_vec};
    end else begin
      verdict.fault = 1'b1;
      verdict.code  = FLT_GP;
    end
  end

endmodule

// File: rtl/xcr_wr_check.sv
module xcr_wr_check
  import xcr_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int INDEX_W = 32,
  parameter int PRIV_W  = 2
) (
  input  logic               os_enable,
  input  logic               guest_mode,
  input  logic [PRIV_W-1:0]  priv,
  input  logic [INDEX_W-1:0] index,
  input  logic [REG_W-1:0]   val_hi,
  input  logic [REG_W-1:0]   val_lo,
  input  logic [REG_W-1:0]   supp_mask,
  output verdict_t           verdict,
  output logic               accept
);

  function automatic logic [REG_W-1:0] wide_bits();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = WIDE_LO; i <= WIDE_HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] WIDE_SEL = wide_bits();
  localparam logic [REG_W-1:0] WIDE_NEED = WIDE_SEL
    | (REG_W'(1) << BIT_X87) | (REG_W'(1) << BIT_VEC) | (REG_W'(1) << BIT_UPVEC);

  logic bad_value;
  logic bad_dep;

  always_comb begin
    bad_value = (val_hi != '0) || ((val_lo & ~supp_mask) != '0) || !val_lo[BIT_X87];
    bad_dep   = (val_lo[BIT_UPVEC] && !val_lo[BIT_VEC])
             || (((val_lo & WIDE_SEL) != '0) && ((val_lo & WIDE_NEED) != WIDE_NEED));
  end

  always_comb begin
    verdict = '{fault: 1'b0, code: FLT_NONE, exit_req: 1'b0};
    accept  = 1'b0;
    if (!os_enable) begin
      verdict.fault = 1'b1;
      verdict.code  = FLT_UD;
    end else if (guest_mode) begin
      verdict.exit_req = 1'b1;
    end else if (priv != '0 || index != '0 || bad_value || bad_dep) begin
      verdict.fault = 1'b1;
      verdict.code  = FLT_GP;
    end else begin
      accept = 1'b1;
    end
  end

endmodule

// File: rtl/xcr_access_unit.sv
module xcr_access_unit
  import xcr_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int INDEX_W = 32,
  parameter int PRIV_W  = 2,
  parameter logic [REG_W-1:0] RESET_VAL = REG_W'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [INDEX_W-1:0] req_index,
  input  logic [REG_W-1:0]   wr_hi,
  input  logic [REG_W-1:0]   wr_lo,
  input  logic [PRIV_W-1:0]  cur_priv,
  input  logic               os_enable,
  input  logic               guest_mode,
  input  logic [REG_W-1:0]   supp_mask,
  input  logic [REG_W-1:0]   inuse_vec,
  input  logic               compact_ok,
  output logic               resp_valid,
  output logic [2*REG_W-1:0] rd_data,
  output logic               fault,
  output logic [1:0]         fault_code,
  output logic               exit_req,
  output logic               mode_chg,
  output logic [REG_W-1:0]   xcr_value
);

  logic [REG_W-1:0]   xcr_q, xcr_d;
  logic               xcr_en;
  logic [2*REG_W-1:0] rd_q, rd_d, rd_path_data;
  verdict_t           rd_verdict, wr_verdict, sel_verdict, verdict_q;
  logic               wr_accept;
  logic               vld_q, chg_q, chg_d;

  xcr_rd_path #(.REG_W(REG_W), .INDEX_W(INDEX_W)) u_rd (
    .os_enable  (os_enable),
    .index      (req_index),
    .compact_ok (compact_ok),
    .xcr        (xcr_q),
    .inuse_vec  (inuse_vec),
    .data       (rd_path_data),
    .verdict    (rd_verdict)
  );

  xcr_wr_check #(.REG_W(REG_W), .INDEX_W(INDEX_W), .PRIV_W(PRIV_W)) u_wr (
    .os_enable  (os_enable),
    .guest_mode (guest_mode),
    .priv       (cur_priv),
    .index      (req_index),
    .val_hi     (wr_hi),
    .val_lo     (wr_lo),
    .supp_mask  (supp_mask),
    .verdict    (wr_verdict),
    .accept     (wr_accept)
  );

  // Next-state
  always_comb begin
    sel_verdict = req_write ? wr_verdict : rd_verdict;
    rd_d        = req_write ? '0 : rd_path_data;
    xcr_en      = req_valid && req_write && wr_accept;
    xcr_d       = wr_lo;
    chg_d       = xcr_en;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcr_q <= RESET_VAL;
    end else if (xcr_en) begin
      xcr_q <= xcr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      chg_q     <= 1'b0;
      rd_q      <= '0;
      verdict_q <= '{fault: 1'b0, code: FLT_NONE, exit_req: 1'b0};
    end else begin
      vld_q <= req_valid;
      chg_q <= chg_d;
      if (req_valid) begin
        rd_q      <= rd_d;
        verdict_q <= sel_verdict;
      end else begin
        verdict_q <= '{fault: 1'b0, code: FLT_NONE, exit_req: 1'b0};
      end
    end
  end

  assign resp_valid = vld_q;
  assign rd_data    = rd_q;
  assign fault      = verdict_q.fault;
  assign fault_code = verdict_q.code;
  assign exit_req   = verdict_q.exit_req;
  assign mode_chg   = chg_q;
  assign xcr_value  = xcr_q;

  // Checks
  AST_BASE_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xcr_q[BIT_X87]) else $error("base bit cleared"); // R8

  AST_UPVEC_NEEDS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !(xcr_q[BIT_UPVEC] && !xcr_q[BIT_VEC])) else $error("upper vector without vector"); // R9

  AST_WIDE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (xcr_q[WIDE_HI:WIDE_LO] == '0) || (xcr_q[WIDE_HI:WIDE_LO] == '1 && xcr_q[BIT_UPVEC:BIT_X87] == '1))
    else $error("wide group partially enabled"); // R10

  AST_FAULT_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (fault || exit_req)) |-> $stable(xcr_q)) else $error("register changed on fault"); // R11

  AST_CHG_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (resp_valid && !fault && !exit_req)) else $error("strobe without clean write"); // R11

  AST_OS_OFF_UD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !os_enable) |=> (fault && fault_code == FLT_UD && !exit_req)) else $error("enable check"); // R2

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid) else $error("missing response"); // R12

  AST_CODE_MATCHES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (fault_code != FLT_NONE)) else $error("code mismatch"); // R2

endmodule

// File: tb/tb_xcr_access_unit.sv
`timescale 1ns/1ps
module tb_xcr_access_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_index = '0, wr_hi = '0, wr_lo = '0;
  logic [1:0]  cur_priv = '0;
  logic        os_enable = 1'b1, guest_mode = 1'b0, compact_ok = 1'b1;
  logic [31:0] supp_mask = 32'hFF, inuse_vec = '0;
  logic        resp_valid, fault, exit_req, mode_chg;
  logic [63:0] rd_data;
  logic [1:0]  fault_code;
  logic [31:0] xcr_value;

  xcr_access_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .wr_hi(wr_hi), .wr_lo(wr_lo), .cur_priv(cur_priv),
    .os_enable(os_enable), .guest_mode(guest_mode), .supp_mask(supp_mask),
    .inuse_vec(inuse_vec), .compact_ok(compact_ok), .resp_valid(resp_valid),
    .rd_data(rd_data), .fault(fault), .fault_code(fault_code), .exit_req(exit_req),
    .mode_chg(mode_chg), .xcr_value(xcr_value)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [63:0] data;
    logic        flt;
    logic [1:0]  code;
    logic        ex;
    logic        chg;
    logic [31:0] regv;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] model = 32'h1;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Driver: model from the requirements, push, present request for one cycle
  task automatic issue(input bit wr, input logic [31:0] idx, input logic [31:0] hi,
                       input logic [31:0] lo, input logic [1:0] pl, input bit os,
                       input bit gst, input bit cmp, input logic [31:0] inuse,
                       input string tag);
    exp_t e;
    e.data = '0; e.flt = 0; e.code = 2'd0; e.ex = 0; e.chg = 0; e.tag = tag;
    if (!os) begin
      e.flt = 1; e.code = 2'd1;
    end else if (!wr) begin
      if (idx == 0) e.data = {32'h0, model};
      else if (idx == 1 && cmp) e.data = {32'h0, model & inuse};
      else begin e.flt = 1; e.code = 2'd2; end
    end else if (gst) begin
      e.ex = 1;
    end else begin
      bit bad;
      bad = (pl != 0) || (idx != 0) || (hi != 0) || ((lo & ~supp_mask) != 0) || !lo[0]
         || (lo[2] && !lo[1])
         || ((lo[7:5] != 0) && ((lo & 32'hE7) != 32'hE7));
      if (bad) begin e.flt = 1; e.code = 2'd2; end
      else begin model = lo; e.chg = 1; end
    end
    e.regv = model;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_index = idx; wr_hi = hi; wr_lo = lo;
    cur_priv = pl; os_enable = os; guest_mode = gst; compact_ok = cmp; inuse_vec = inuse;
    @(negedge clk);
    req_valid = 0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resp_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R12", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rd_data == e.data, e.tag, "rd_data", rd_data, e.data);
          chk(fault == e.flt && fault_code == e.code, e.tag, "fault/code",
              {fault, fault_code}, {e.flt, e.code});
          chk(exit_req == e.ex, e.tag, "exit_req", exit_req, e.ex);
          chk(mode_chg == e.chg, e.tag, "mode_chg", mode_chg, e.chg);
          chk(xcr_value == e.regv, e.tag, "xcr_value", xcr_value, e.regv);
        end
      end else begin
        chk(mode_chg == 0, "R11", "strobe outside response", mode_chg, 0);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(xcr_value == 32'h1, "R1", "reset value", xcr_value, 32'h1);
    chk(!resp_valid && !fault && !exit_req && !mode_chg, "R1", "idle outputs",
        {resp_valid, fault, exit_req, mode_chg}, 0);

    issue(0, 0, 0, 0, 0, 1, 0, 1, 0, "R3");              // read idx0
    issue(0, 0, 0, 0, 0, 0, 0, 1, 0, "R2");              // read, os off
    issue(1, 0, 0, 32'h3, 0, 0, 0, 1, 0, "R2");          // write, os off
    issue(1, 0, 0, 32'h3, 3, 0, 1, 1, 0, "R6");          // guest, os off -> UD
    issue(1, 0, 0, 32'h3, 0, 1, 0, 1, 0, "R11");         // legal write
    issue(0, 0, 0, 0, 0, 1, 0, 1, 0, "R3");
    issue(0, 1, 0, 0, 0, 1, 0, 1, 32'hF2, "R4");          // inuse & reg = 2
    issue(0, 1, 0, 0, 0, 1, 0, 0, 32'hF2, "R4");          // no compaction
    issue(0, 2, 0, 0, 0, 1, 0, 1, 0, "R5");
    issue(0, 32'h100, 0, 0, 0, 1, 0, 1, 0, "R5");
    issue(1, 0, 0, 32'h7, 3, 1, 1, 1, 0, "R6");          // exit over priv
    issue(1, 0, 0, 32'h7, 3, 1, 0, 1, 0, "R7");
    issue(1, 1, 0, 32'h7, 0, 1, 0, 1, 0, "R7");
    issue(1, 0, 32'h1, 32'h7, 0, 1, 0, 1, 0, "R8");
    issue(1, 0, 0, 32'h103, 0, 1, 0, 1, 0, "R8");        // outside supported
    issue(1, 0, 0, 32'h6, 0, 1, 0, 1, 0, "R8");          // base bit clear
    issue(1, 0, 0, 32'h5, 0, 1, 0, 1, 0, "R9");
    issue(0, 0, 0, 0, 0, 1, 0, 1, 0, "R11");             // still 0x3
    issue(1, 0, 0, 32'h7, 0, 1, 0, 1, 0, "R9");          // legal
    issue(1, 0, 0, 32'h27, 0, 1, 0, 1, 0, "R10");
    issue(1, 0, 0, 32'hE3, 0, 1, 0, 1, 0, "R10");
    issue(1, 0, 0, 32'h67, 0, 1, 0, 1, 0, "R10");
    issue(1, 0, 0, 32'hE7, 0, 1, 0, 1, 0, "R10");        // legal
    issue(0, 0, 0, 0, 0, 1, 0, 1, 0, "R3");
    issue(1, 0, 0, 32'h3, 0, 1, 0, 1, 0, "R11");
    issue(0, 1, 0, 0, 0, 1, 0, 1, 32'hFFFFFFFF, "R4");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R12", "responses outstanding", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule